// File: doc/BRIEF.md
# Test-port instruction and bypass controller

This block holds the instruction side of a boundary-scan test port on a part that carries no identification register. It contains an 8-bit instruction shift register, the decoder that turns a loaded opcode into mode controls for the boundary register, and the single-stage bypass register. It also drives the serial test output. The port state machine is outside the block. It reports its current state through one-hot level inputs, and those inputs are taken to be valid for the whole TCK period that starts at the rising edge where the state is entered. The boundary cells are also outside the block and return their serial output on `bsr_tdo_i`.

Shift and capture actions happen on the rising TCK edge. The active instruction and the serial output change on the falling edge. When the instruction register is captured it loads a fixed pattern. The two low bits of that pattern are the mandatory `01`, and the upper six bits serve as a pseudo-identity for the part. Four opcodes are recognised. Every other code falls back to bypass.

Top module: `tapir_ctl`

## Requirements
- R1: Capture-IR loads 8'h3D (binary 00111101). In Shift-IR the register moves one place toward bit 0 on each rising edge, and `tdi_i` enters at bit 7. Bit 0 is presented on `tdo_o`, so the LSB comes out first.
- R2: The active instruction, and with it every mode output, changes only on a falling TCK edge while in Update-IR (or under R9). It does not change while a new code is still being shifted or is waiting in Exit.
- R3: Opcode 8'h00 (boundary drive) gives bsr_sel=1, bsr_drive=1, out_hiz=0, byp_sel=0. Opcode 8'h81 (sample/preload) gives bsr_sel=1, bsr_drive=0, out_hiz=0, byp_sel=0.
- R4: Opcode 8'h82 (clamp) gives bsr_drive=1 and byp_sel=1, with bsr_sel=0 and out_hiz=0. The data path then runs through the bypass stage.
- R5: Opcode 8'h03 (high-impedance) gives out_hiz=1 and byp_sel=1, with bsr_sel=0 and bsr_drive=0.
- R6: Every other opcode selects bypass: byp_sel=1 and the other three mode outputs 0.
- R7: The bypass stage loads 0 in Capture-DR. In Shift-DR it delays `tdi_i` by exactly one TCK.
- R8: When bsr_sel=1, `tdo_o` in Shift-DR carries `bsr_tdo_i` as sampled on the falling edge.
- R9: An asserted `rst_ni` low, or a falling edge in Test-Logic-Reset, forces the bypass instruction.
- R10: `tdo_o` and `tdo_oe_o` change only on falling edges. `tdo_oe_o` is 1 only after a falling edge in Shift-IR or Shift-DR, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tdi_i | input | 1 | Serial test data in |
| tlr_i | input | 1 | State is Test-Logic-Reset |
| capture_ir_i | input | 1 | State is Capture-IR |
| shift_ir_i | input | 1 | State is Shift-IR |
| update_ir_i | input | 1 | State is Update-IR |
| capture_dr_i | input | 1 | State is Capture-DR |
| shift_dr_i | input | 1 | State is Shift-DR |
| bsr_tdo_i | input | 1 | Serial output of the boundary register |
| bsr_sel_o | output | 1 | Boundary register is the data register in use |
| bsr_drive_o | output | 1 | Device outputs are driven from the boundary update stage |
| out_hiz_o | output | 1 | All device outputs are forced disabled |
| byp_sel_o | output | 1 | Bypass stage is the data register in use |
| tdo_o | output | 1 | Serial test data out |
| tdo_oe_o | output | 1 | Output enable for `tdo_o` |

## Verification
The hardest case to reach from the ports is a code that has been shifted in completely but not yet applied. The bench reaches it by loading a new opcode while a different instruction is active, then stopping in an Exit state for a full period. During that period it checks that the mode outputs still reflect the old instruction. The falling-edge timing of `tdo_o` is checked in the same way: the bench samples just after the rising edge that shifts the bypass stage, where the old bit must still be present, and again after the following falling edge, where the new bit must appear.

// File: rtl/tapir_pkg.sv
package tapir_pkg;
  typedef enum logic [2:0] {
    INS_BYPASS = 3'd0,
    INS_EXTEST = 3'd1,
    INS_SAMPLE = 3'd2,
    INS_CLAMP  = 3'd3,
    INS_HIGHZ  = 3'd4
  } instr_e;

  typedef struct packed {
    logic bsr_sel;
    logic bsr_drive;
    logic out_hiz;
    logic byp_sel;
  } mode_t;
endpackage

// File: rtl/tapir_ir_shift.sv
module tapir_ir_shift #(
  parameter int unsigned IR_W = 8,
  parameter logic [IR_W-1:0] CAPTURE = 8'h3D
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  logic            shift_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] sr_o
);
  logic [IR_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= CAPTURE;
    else if (capture_i) sr_q <= CAPTURE;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[IR_W-1:1]};
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/tapir_instr_hold.sv
module tapir_instr_hold
  import tapir_pkg::*;
#(
  parameter int unsigned IR_W = 8,
  parameter logic [IR_W-1:0] OP_EXTEST = 8'h00,
  parameter logic [IR_W-1:0] OP_SAMPLE = 8'h81,
  parameter logic [IR_W-1:0] OP_CLAMP  = 8'h82,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 8'h03
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tlr_i,
  input  logic            update_i,
  input  logic [IR_W-1:0] code_i,
  output mode_t           mode_o
);
  instr_e dec;
  instr_e ins_q;

  always_comb begin
    unique case (code_i)
      OP_EXTEST: dec = INS_EXTEST;
      OP_SAMPLE: dec = INS_SAMPLE;
      OP_CLAMP:  dec = INS_CLAMP;
      OP_HIGHZ:  dec = INS_HIGHZ;
      default:   dec = INS_BYPASS;
    endcase
  end

  // instruction is applied on the falling edge only
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       ins_q <= INS_BYPASS;
    else if (tlr_i)    ins_q <= INS_BYPASS;
    else if (update_i) ins_q <= dec;
  end

  always_comb begin
    mode_o = '{bsr_sel: 1'b0, bsr_drive: 1'b0, out_hiz: 1'b0, byp_sel: 1'b1};
    case (ins_q)
      INS_EXTEST: mode_o = '{bsr_sel: 1'b1, bsr_drive: 1'b1, out_hiz: 1'b0, byp_sel: 1'b0};
      INS_SAMPLE: mode_o = '{bsr_sel: 1'b1, bsr_drive: 1'b0, out_hiz: 1'b0, byp_sel: 1'b0};
      INS_CLAMP:  mode_o = '{bsr_sel: 1'b0, bsr_drive: 1'b1, out_hiz: 1'b0, byp_sel: 1'b1};
      INS_HIGHZ:  mode_o = '{bsr_sel: 1'b0, bsr_drive: 1'b0, out_hiz: 1'b1, byp_sel: 1'b1};
      default:    ;
    endcase
  end
endmodule

// File: rtl/tapir_bypass.sv
module tapir_bypass (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic tdi_i,
  output logic bit_o
);
  logic q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        q <= 1'b0;
    else if (capture_i) q <= 1'b0;
    else if (shift_i)   q <= tdi_i;
  end

  assign bit_o = q;
endmodule

// File: rtl/tapir_tdo.sv
module tapir_tdo (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic shift_ir_i,
  input  logic shift_dr_i,
  input  logic ir_bit_i,
  input  logic dr_bit_i,
  output logic tdo_o,
  output logic tdo_oe_o
);
  logic tdo_q, oe_q;

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= shift_ir_i | shift_dr_i;
      if (shift_ir_i)      tdo_q <= ir_bit_i;
      else if (shift_dr_i) tdo_q <= dr_bit_i;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;
endmodule

// File: rtl/tapir_ctl.sv
module tapir_ctl
  import tapir_pkg::*;
#(
  parameter int unsigned IR_W = 8,
  parameter logic [IR_W-1:0] CAPTURE   = 8'h3D,
  parameter logic [IR_W-1:0] OP_EXTEST = 8'h00,
  parameter logic [IR_W-1:0] OP_SAMPLE = 8'h81,
  parameter logic [IR_W-1:0] OP_CLAMP  = 8'h82,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 8'h03
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tdi_i,
  input  logic tlr_i,
  input  logic capture_ir_i,
  input  logic shift_ir_i,
  input  logic update_ir_i,
  input  logic capture_dr_i,
  input  logic shift_dr_i,
  input  logic bsr_tdo_i,
  output logic bsr_sel_o,
  output logic bsr_drive_o,
  output logic out_hiz_o,
  output logic byp_sel_o,
  output logic tdo_o,
  output logic tdo_oe_o
);
  logic [IR_W-1:0] ir_sr;
  mode_t           mode;
  logic            byp_bit;
  logic            dr_bit;

  tapir_ir_shift #(.IR_W(IR_W), .CAPTURE(CAPTURE)) u_ir (
    .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_ir_i),
    .shift_i(shift_ir_i), .tdi_i(tdi_i), .sr_o(ir_sr)
  );

  tapir_instr_hold #(
    .IR_W(IR_W), .OP_EXTEST(OP_EXTEST), .OP_SAMPLE(OP_SAMPLE),
    .OP_CLAMP(OP_CLAMP), .OP_HIGHZ(OP_HIGHZ)
  ) u_hold (
    .tck_i(tck_i), .rst_ni(rst_ni), .tlr_i(tlr_i),
    .update_i(update_ir_i), .code_i(ir_sr), .mode_o(mode)
  );

  tapir_bypass u_byp (
    .tck_i(tck_i), .rst_ni(rst_ni), .capture_i(capture_dr_i),
    .shift_i(shift_dr_i), .tdi_i(tdi_i), .bit_o(byp_bit)
  );

  assign dr_bit = mode.bsr_sel ? bsr_tdo_i : byp_bit;

  tapir_tdo u_tdo (
    .tck_i(tck_i), .rst_ni(rst_ni), .shift_ir_i(shift_ir_i),
    .shift_dr_i(shift_dr_i), .ir_bit_i(ir_sr[0]), .dr_bit_i(dr_bit),
    .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o)
  );

  assign bsr_sel_o   = mode.bsr_sel;
  assign bsr_drive_o = mode.bsr_drive;
  assign out_hiz_o   = mode.out_hiz;
  assign byp_sel_o   = mode.byp_sel;
endmodule

// File: rtl/tapir_ctl_chk.sv
module tapir_ctl_chk (
  input logic tck_i,
  input logic rst_ni,
  input logic tlr_i,
  input logic update_ir_i,
  input logic shift_ir_i,
  input logic shift_dr_i,
  input logic bsr_sel_o,
  input logic bsr_drive_o,
  input logic out_hiz_o,
  input logic byp_sel_o,
  input logic tdo_oe_o
);
  AST_ONE_DATA_PATH: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot({bsr_sel_o, byp_sel_o})); // R6

  AST_HIZ_ON_BYPASS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    out_hiz_o |-> (byp_sel_o && !bsr_drive_o)); // R5

  AST_DRIVE_PATH: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (bsr_drive_o && !bsr_sel_o) |-> (byp_sel_o && !out_hiz_o)); // R4

  AST_MODE_ON_UPDATE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable({bsr_sel_o, bsr_drive_o, out_hiz_o, byp_sel_o}) |-> (update_ir_i || tlr_i)); // R2

  AST_TLR_BYPASS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |-> (byp_sel_o && !bsr_drive_o && !out_hiz_o)); // R9

  AST_TDO_OE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == (shift_ir_i || shift_dr_i)); // R10
endmodule

bind tapir_ctl tapir_ctl_chk u_chk (.*);

// File: tb/tapir_ctl_bench.sv
module tapir_ctl_bench;
  logic tck = 1'b0;
  logic rst_ni = 1'b0;
  logic tdi = 1'b0, bdo = 1'b0;
  logic tlr = 1'b0, cap_ir = 1'b0, sh_ir = 1'b0, upd_ir = 1'b0, cap_dr = 1'b0, sh_dr = 1'b0;
  logic bsr_sel, bsr_drive, out_hiz, byp_sel, tdo, tdo_oe;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  localparam logic [5:0] S_IDLE = 6'b000000, S_TLR = 6'b000001, S_CIR = 6'b000010,
                         S_SIR = 6'b000100, S_UIR = 6'b001000, S_CDR = 6'b010000,
                         S_SDR = 6'b100000;
  localparam logic [3:0] M_EXT = 4'b1100, M_SMP = 4'b1000, M_CLP = 4'b0101,
                         M_HIZ = 4'b0011, M_BYP = 4'b0001;

  always #10 tck = ~tck;

  tapir_ctl u_tapir_ctl (
    .tck_i(tck), .rst_ni(rst_ni), .tdi_i(tdi), .tlr_i(tlr),
    .capture_ir_i(cap_ir), .shift_ir_i(sh_ir), .update_ir_i(upd_ir),
    .capture_dr_i(cap_dr), .shift_dr_i(sh_dr), .bsr_tdo_i(bdo),
    .bsr_sel_o(bsr_sel), .bsr_drive_o(bsr_drive), .out_hiz_o(out_hiz),
    .byp_sel_o(byp_sel), .tdo_o(tdo), .tdo_oe_o(tdo_oe)
  );

  function automatic logic [3:0] modes();
    return {bsr_sel, bsr_drive, out_hiz, byp_sel};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_state(input logic [5:0] st, input logic d, input logic b);
    {sh_dr, cap_dr, upd_ir, sh_ir, cap_ir, tlr} = st;
    tdi = d;
    bdo = b;
  endtask

  // one TAP state: entered after a rising edge, sampled after the falling edge
  task automatic tick(input logic [5:0] st, input logic d = 1'b0, input logic b = 1'b0);
    @(posedge tck);
    #2 set_state(st, d, b);
    @(negedge tck);
    #5;
  endtask

  task automatic load_ir(input logic [7:0] op);
    tick(S_CIR);
    for (int i = 0; i < 8; i++) tick(S_SIR, op[i]);
    tick(S_IDLE);
    tick(S_UIR);
    tick(S_IDLE);
  endtask

  task automatic t_reset();
    check("R9 reset modes", modes(), M_BYP);
    check("R10 reset oe", tdo_oe, 1'b0);
  endtask

  task automatic t_ir_capture();
    logic [7:0] pat = 8'b1001_0110;
    tick(S_CIR);
    check("R10 oe off in capture", tdo_oe, 1'b0);
    for (int i = 0; i < 16; i++) begin
      tick(S_SIR, i < 8 ? pat[i] : 1'b0);
      check("R10 oe in shift-ir", tdo_oe, 1'b1);
      if (i < 8) check("R1 captured bit", tdo, 8'h3D >> i & 1);
      else       check("R1 shifted-through bit", tdo, pat[i-8]);
    end
    tick(S_IDLE);
    check("R10 oe off after shift", tdo_oe, 1'b0);
    check("R2 no update yet", modes(), M_BYP);
  endtask

  task automatic t_decode();
    load_ir(8'h00); check("R3 extest modes", modes(), M_EXT);
    load_ir(8'h81); check("R3 sample modes", modes(), M_SMP);
    load_ir(8'h82); check("R4 clamp modes", modes(), M_CLP);
    load_ir(8'h03); check("R5 highz modes", modes(), M_HIZ);
    load_ir(8'hFF); check("R6 ff bypass", modes(), M_BYP);
    load_ir(8'h01); check("R6 01 bypass", modes(), M_BYP);
    load_ir(8'h80); check("R6 80 bypass", modes(), M_BYP);
    load_ir(8'h83); check("R6 83 bypass", modes(), M_BYP);
    load_ir(8'h02); check("R6 02 bypass", modes(), M_BYP);
  endtask

  task automatic t_update_timing();
    logic [7:0] op = 8'h82;
    load_ir(8'h00);
    tick(S_CIR);
    for (int i = 0; i < 8; i++) tick(S_SIR, op[i]);
    tick(S_IDLE);
    check("R2 held while in exit", modes(), M_EXT);
    tick(S_UIR);
    check("R2 applied at update", modes(), M_CLP);
  endtask

  task automatic t_bypass();
    load_ir(8'hFF);
    tick(S_CDR);
    tick(S_SDR, 1'b1, 1'b1);
    check("R7 captured zero", tdo, 1'b0);
    tick(S_SDR, 1'b0, 1'b1);
    check("R7 one-cycle delay a", tdo, 1'b1);
    @(posedge tck);
    #1 check("R10 tdo held past rising edge", tdo, 1'b1);
    #1 set_state(S_SDR, 1'b1, 1'b1);
    @(negedge tck);
    #5 check("R7 one-cycle delay b", tdo, 1'b0);
    tick(S_IDLE);
    check("R10 oe off after dr shift", tdo_oe, 1'b0);
    // clamp keeps the path through bypass
    load_ir(8'h82);
    tick(S_CDR);
    tick(S_SDR, 1'b1, 1'b1);
    check("R4 clamp shifts bypass", tdo, 1'b0);
    tick(S_SDR, 1'b0, 1'b1);
    check("R4 clamp bypass delay", tdo, 1'b1);
  endtask

  task automatic t_boundary();
    load_ir(8'h81);
    tick(S_CDR);
    tick(S_SDR, 1'b0, 1'b1);
    check("R8 boundary bit 1", tdo, 1'b1);
    tick(S_SDR, 1'b1, 1'b0);
    check("R8 boundary bit 0", tdo, 1'b0);
    tick(S_IDLE);
  endtask

  task automatic t_tlr();
    load_ir(8'h00);
    check("R9 before tlr", modes(), M_EXT);
    tick(S_TLR);
    check("R9 tlr forces bypass", modes(), M_BYP);
    tick(S_IDLE);
    load_ir(8'h03);
    rst_ni = 1'b0;
    #1 check("R9 async reset bypass", modes(), M_BYP);
    @(posedge tck);
    #2 rst_ni = 1'b1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge tck);
    #2 rst_ni = 1'b1;
    @(negedge tck);
    #5;
    t_reset();
    t_ir_capture();
    t_decode();
    t_update_timing();
    t_bypass();
    t_boundary();
    t_tlr();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule